// File: doc/BRIEF.md
# Partitioned SIMD Compare Unit

This unit compares two 64-bit source operands lane by lane and returns the per-lane outcomes as a compact bit mask. The operands are split either into four signed 16-bit lanes or into two signed 32-bit lanes. The relation tested in every lane is one of four: signed greater-than, signed less-or-equal, equal or not-equal. The mask is zero-extended to a full 64-bit word so that it can be written to a general-purpose integer register. It is not meant for the floating-point register file.

An issuing pipeline drives an opcode and both operands together with a valid strobe. One clock later the unit presents the registered mask with a valid flag. If the opcode is not one of the eight compare encodings, the unit instead pulses an illegal-opcode flag. The first source always stands on the left of the relation.

Top module: `lane_cmp_unit`

## Requirements
- R1: Opcode bit 2 selects the lane width (0: four 16-bit lanes, 1: two 32-bit lanes). Lane 0 occupies the least-significant bits of each operand (bits 15:0 or 31:0), and lane i occupies the next slice up.
- R2: The outcome of lane i is placed in result bit i, giving weights 1, 2, 4, 8 for 16-bit lanes and 1, 2 for 32-bit lanes.
- R3: Every result bit above the mask is zero: bits 63:4 for the 16-bit forms and bits 63:2 for the 32-bit forms.
- R4: Each lane evaluates first-source relation second-source (srcA op srcB), never the reverse.
- R5: Greater-than and less-or-equal treat each lane as a two's-complement signed number.
- R6: Equal sets a lane bit when the lane values are bit-identical. Not-equal is its exact per-lane complement.
- R7: Less-or-equal is the exact per-lane complement of signed greater-than.
- R8: The accepted encodings are 0x020 le16, 0x022 ne16, 0x024 le32, 0x026 ne32, 0x028 gt16, 0x02a eq16, 0x02c gt32 and 0x02e eq32, on a 9-bit opcode.
- R9: A valid input whose opcode is outside R8 raises outIllegal for one cycle. It leaves outValid low and outResult unchanged.
- R10: outValid rises exactly one clock after a valid legal input. A synchronous active-high reset clears outValid, outIllegal and outResult, and it overrides a valid input in the same cycle.
- R11: A cycle with inValid low produces neither outValid nor outIllegal in the next cycle, and it leaves outResult unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Opcode and operands are valid this cycle |
| inOpcode | input | 9 | Compare opcode (R8) |
| inSrcA | input | 64 | First source operand |
| inSrcB | input | 64 | Second source operand |
| outValid | output | 1 | outResult holds a new mask |
| outIllegal | output | 1 | Previous-cycle input carried an unknown opcode |
| outResult | output | 64 | Zero-extended lane mask for the integer register |

## Verification
A result can leave the output register in the same cycle that the next operation is accepted. That next operation may be legal or illegal. It is also possible for a reset to arrive together with a valid input. The bench issues legal and illegal opcodes back to back, with and without idle gaps. A scoreboard judges every cycle's outValid, outIllegal and held outResult against a reference model. A separate step asserts reset during a valid legal compare and expects all outputs to read zero afterwards.

// File: rtl/lane_cmp_pkg.sv
package lane_cmp_pkg;

  localparam int OPC_W = 9;

  // Compare opcodes (R8)
  localparam logic [OPC_W-1:0] OPC_LE16 = 9'h020;
  localparam logic [OPC_W-1:0] OPC_NE16 = 9'h022;
  localparam logic [OPC_W-1:0] OPC_LE32 = 9'h024;
  localparam logic [OPC_W-1:0] OPC_NE32 = 9'h026;
  localparam logic [OPC_W-1:0] OPC_GT16 = 9'h028;
  localparam logic [OPC_W-1:0] OPC_EQ16 = 9'h02a;
  localparam logic [OPC_W-1:0] OPC_GT32 = 9'h02c;
  localparam logic [OPC_W-1:0] OPC_EQ32 = 9'h02e;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;    // capture a new mask
    logic bad;     // flag an unknown opcode
    logic wide;    // 32-bit lanes when set
    logic useEq;   // equality family when set, ordering family otherwise
    logic invert;  // complement the base relation (le, ne)
  } cmpStrobe_t;

endpackage

// File: rtl/lane_cmp_lane.sv
module lane_cmp_lane #(
  parameter int LANE_W = 16
) (
  input  logic [LANE_W-1:0] laneA,
  input  logic [LANE_W-1:0] laneB,
  output logic              laneGt,
  output logic              laneEq
);

  // laneA on the left of the relation (R4), signed order (R5)
  always_comb begin
    laneGt = $signed(laneA) > $signed(laneB);
    laneEq = (laneA == laneB);
  end

endmodule

// File: rtl/lane_cmp_ctrl.sv
module lane_cmp_ctrl
  import lane_cmp_pkg::*;
(
  input  logic             inValid,
  input  logic [OPC_W-1:0] inOpcode,
  output cmpStrobe_t       strobe
);

  logic       legal;
  logic       wideSel;
  logic       eqSel;
  logic       invSel;

  // Opcode decode (R8); le and ne are complements (R6, R7)
  always_comb begin
    legal   = 1'b1;
    wideSel = 1'b0;
    eqSel   = 1'b0;
    invSel  = 1'b0;
    unique case (inOpcode)
      OPC_GT16: begin wideSel = 1'b0; eqSel = 1'b0; invSel = 1'b0; end
      OPC_LE16: begin wideSel = 1'b0; eqSel = 1'b0; invSel = 1'b1; end
      OPC_EQ16: begin wideSel = 1'b0; eqSel = 1'b1; invSel = 1'b0; end
      OPC_NE16: begin wideSel = 1'b0; eqSel = 1'b1; invSel = 1'b1; end
      OPC_GT32: begin wideSel = 1'b1; eqSel = 1'b0; invSel = 1'b0; end
      OPC_LE32: begin wideSel = 1'b1; eqSel = 1'b0; invSel = 1'b1; end
      OPC_EQ32: begin wideSel = 1'b1; eqSel = 1'b1; invSel = 1'b0; end
      OPC_NE32: begin wideSel = 1'b1; eqSel = 1'b1; invSel = 1'b1; end
      default:  legal = 1'b0;
    endcase
  end

  always_comb begin
    strobe.take   = inValid && legal;
    strobe.bad    = inValid && !legal;   // R9
    strobe.wide   = wideSel;
    strobe.useEq  = eqSel;
    strobe.invert = invSel;
  end

endmodule

// File: rtl/lane_cmp_dp.sv
module lane_cmp_dp
  import lane_cmp_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  cmpStrobe_t        strobe,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              resValid,
  output logic              resIllegal,
  output logic [DATA_W-1:0] resWord
);

  localparam int NARROW_LANES = DATA_W / NARROW_W;
  localparam int WIDE_LANES   = DATA_W / WIDE_W;

  logic [NARROW_LANES-1:0] narrowGt, narrowEq, narrowRel;
  logic [WIDE_LANES-1:0]   wideGt, wideEq, wideRel;
  logic [DATA_W-1:0]       maskNext;

  // Narrow lane comparators, lane 0 at the bottom (R1)
  for (genvar i = 0; i < NARROW_LANES; i++) begin : g_narrow
    lane_cmp_lane #(.LANE_W(NARROW_W)) u_lane (
      .laneA (srcA[i*NARROW_W +: NARROW_W]),
      .laneB (srcB[i*NARROW_W +: NARROW_W]),
      .laneGt(narrowGt[i]),
      .laneEq(narrowEq[i])
    );
  end

  // Wide lane comparators (R1)
  for (genvar j = 0; j < WIDE_LANES; j++) begin : g_wide
    lane_cmp_lane #(.LANE_W(WIDE_W)) u_lane (
      .laneA (srcA[j*WIDE_W +: WIDE_W]),
      .laneB (srcB[j*WIDE_W +: WIDE_W]),
      .laneGt(wideGt[j]),
      .laneEq(wideEq[j])
    );
  end

  // Relation select and complement (R6, R7)
  always_comb begin
    narrowRel = (strobe.useEq ? narrowEq : narrowGt)
                ^ {NARROW_LANES{strobe.invert}};
    wideRel   = (strobe.useEq ? wideEq : wideGt)
                ^ {WIDE_LANES{strobe.invert}};
  end

  // Packing: lane i to bit i, zero above (R2, R3)
  always_comb begin
    maskNext = '0;
    if (strobe.wide) maskNext[WIDE_LANES-1:0]   = wideRel;
    else             maskNext[NARROW_LANES-1:0] = narrowRel;
  end

  // Output register (R9, R10, R11)
  always_ff @(posedge clk) begin
    if (rst) begin
      resValid   <= 1'b0;
      resIllegal <= 1'b0;
      resWord    <= '0;
    end else begin
      resValid   <= strobe.take;
      resIllegal <= strobe.bad;
      if (strobe.take) resWord <= maskNext;
    end
  end

endmodule

// File: rtl/lane_cmp_unit.sv
module lane_cmp_unit
  import lane_cmp_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [OPC_W-1:0]  inOpcode,
  input  logic [DATA_W-1:0] inSrcA,
  input  logic [DATA_W-1:0] inSrcB,
  output logic              outValid,
  output logic              outIllegal,
  output logic [DATA_W-1:0] outResult
);

  cmpStrobe_t strobe;

  lane_cmp_ctrl u_ctrl (
    .inValid (inValid),
    .inOpcode(inOpcode),
    .strobe  (strobe)
  );

  lane_cmp_dp #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W),
    .WIDE_W  (WIDE_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .srcA      (inSrcA),
    .srcB      (inSrcB),
    .resValid  (outValid),
    .resIllegal(outIllegal),
    .resWord   (outResult)
  );

endmodule

// File: rtl/lane_cmp_chk.sv
module lane_cmp_chk
  import lane_cmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [OPC_W-1:0]  inOpcode,
  input logic [DATA_W-1:0] inSrcA,
  input logic [DATA_W-1:0] inSrcB,
  input logic              outValid,
  input logic              outIllegal,
  input logic [DATA_W-1:0] outResult
);

  function automatic logic isLegal(input logic [OPC_W-1:0] op);
    return (op == OPC_LE16) || (op == OPC_NE16) || (op == OPC_LE32) ||
           (op == OPC_NE32) || (op == OPC_GT16) || (op == OPC_EQ16) ||
           (op == OPC_GT32) || (op == OPC_EQ32);
  endfunction

  function automatic logic isWide(input logic [OPC_W-1:0] op);
    return (op == OPC_LE32) || (op == OPC_NE32) ||
           (op == OPC_GT32) || (op == OPC_EQ32);
  endfunction

  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (rst)
    (inValid && isLegal(inOpcode)) |=> (outValid && !outIllegal));

  assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (inValid && !isLegal(inOpcode)) |=> (outIllegal && !outValid && $stable(outResult)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !outIllegal && $stable(outResult)));

  assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outResult[DATA_W-1:4] == '0));

  assert_wide_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (inValid && isWide(inOpcode)) |=> (outResult[DATA_W-1:2] == '0));

  assert_eq32_lanes_R6: assert property (@(posedge clk) disable iff (rst)
    (inValid && inOpcode == OPC_EQ32) |=>
      (outResult[0] == ($past(inSrcA[31:0]) == $past(inSrcB[31:0])) &&
       outResult[1] == ($past(inSrcA[DATA_W-1:32]) == $past(inSrcB[DATA_W-1:32]))));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({outValid, outIllegal}));

endmodule

bind lane_cmp_unit lane_cmp_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .inOpcode  (inOpcode),
  .inSrcA    (inSrcA),
  .inSrcB    (inSrcB),
  .outValid  (outValid),
  .outIllegal(outIllegal),
  .outResult (outResult)
);

// File: tb/lane_cmp_unit_tb.sv
`timescale 1ns/1ps
module lane_cmp_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [8:0]  inOpcode = '0;
  logic [63:0] inSrcA = '0;
  logic [63:0] inSrcB = '0;
  logic        outValid;
  logic        outIllegal;
  logic [63:0] outResult;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  lane_cmp_unit u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inOpcode(inOpcode),
    .inSrcA(inSrcA), .inSrcB(inSrcB),
    .outValid(outValid), .outIllegal(outIllegal), .outResult(outResult)
  );

  typedef struct {
    logic        v;
    logic        ill;
    logic [63:0] res;
    string       tag;
  } exp_t;

  exp_t sb[$];
  logic [63:0] lastRes = '0;

  localparam logic [8:0] LE16 = 9'h020, NE16 = 9'h022, LE32 = 9'h024, NE32 = 9'h026;
  localparam logic [8:0] GT16 = 9'h028, EQ16 = 9'h02a, GT32 = 9'h02c, EQ32 = 9'h02e;

  function automatic bit legalOp(input logic [8:0] op);
    return op inside {LE16, NE16, LE32, NE32, GT16, EQ16, GT32, EQ32};
  endfunction

  // Independent reference model from the requirements
  function automatic logic [63:0] refCmp(input logic [8:0] op, input logic [63:0] a, b);
    logic [63:0] r = '0;
    if (op inside {LE16, NE16, GT16, EQ16}) begin
      for (int i = 0; i < 4; i++) begin
        logic signed [15:0] x = a[i*16 +: 16];
        logic signed [15:0] y = b[i*16 +: 16];
        case (op)
          GT16: r[i] = (x > y);
          LE16: r[i] = (x <= y);
          EQ16: r[i] = (x == y);
          default: r[i] = (x != y);
        endcase
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic signed [31:0] x = a[i*32 +: 32];
        logic signed [31:0] y = b[i*32 +: 32];
        case (op)
          GT32: r[i] = (x > y);
          LE32: r[i] = (x <= y);
          EQ32: r[i] = (x == y);
          default: r[i] = (x != y);
        endcase
      end
    end
    return r;
  endfunction

  task automatic drive(input logic v, input logic [8:0] op,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    inValid = v; inOpcode = op; inSrcA = a; inSrcB = b;
    e.tag = tag;
    if (v && legalOp(op)) begin
      lastRes = refCmp(op, a, b);
      e.v = 1'b1; e.ill = 1'b0;
    end else if (v) begin
      e.v = 1'b0; e.ill = 1'b1;
    end else begin
      e.v = 1'b0; e.ill = 1'b0;
    end
    e.res = lastRes;
    sb.push_back(e);
  endtask

  task automatic idle();
    drive(1'b0, 9'h000, '0, '0, "R11 idle");
  endtask

  // Monitor: pop one expected item per cycle
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (outValid !== e.v || outIllegal !== e.ill || outResult !== e.res) begin
        errors++;
        $display("FAIL %s: got v=%0b ill=%0b res=%h, expected v=%0b ill=%0b res=%h",
                 e.tag, outValid, outIllegal, outResult, e.v, e.ill, e.res);
      end
    end
  end

  task automatic checkZero(input string tag);
    checks++;
    if (outValid !== 1'b0 || outIllegal !== 1'b0 || outResult !== 64'h0) begin
      errors++;
      $display("FAIL %s: got v=%0b ill=%0b res=%h, expected v=0 ill=0 res=0",
               tag, outValid, outIllegal, outResult);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 checkZero("R10 reset state");
    @(negedge clk) rst = 1'b0;

    // R6 eq16: lanes 1 and 3 equal -> 0xA; R2 weights
    drive(1, EQ16, 64'h1111_2222_3333_4444, 64'h1111_0000_3333_0000, "R6 R2 eq16");
    // R6 ne16 complement -> 0x5
    drive(1, NE16, 64'h1111_2222_3333_4444, 64'h1111_0000_3333_0000, "R6 ne16");
    // R5 signed: 0x8000 is negative, not greater than 1; 0x7fff > 0xffff(-1)
    drive(1, GT16, 64'h0005_7fff_0002_8000, 64'h0005_ffff_0001_0001, "R5 gt16 signed");
    // R4 order swapped operands
    drive(1, GT16, 64'h0005_ffff_0001_0001, 64'h0005_7fff_0002_8000, "R4 gt16 swapped");
    // R7 le16 includes equal lanes
    drive(1, LE16, 64'h0005_7fff_0002_8000, 64'h0005_ffff_0001_0001, "R7 le16");
    // Back-to-back legal then illegal then legal (R9)
    drive(1, 9'h021, 64'hffff_ffff_ffff_ffff, 64'h0, "R9 illegal 0x021");
    drive(1, 9'h12a, 64'h0, 64'h0, "R9 illegal 0x12a");
    // 32-bit forms (R1, R3)
    drive(1, EQ32, 64'hdead_beef_0000_0001, 64'hdead_beef_0000_0002, "R1 R3 eq32");
    drive(1, NE32, 64'hdead_beef_0000_0001, 64'hdead_beef_0000_0002, "R6 ne32");
    drive(1, GT32, 64'h8000_0000_7fff_ffff, 64'h0000_0001_8000_0000, "R5 gt32 signed");
    drive(1, GT32, 64'h0000_0001_8000_0000, 64'h8000_0000_7fff_ffff, "R4 gt32 swapped");
    drive(1, LE32, 64'h1234_5678_8000_0000, 64'h1234_5678_7fff_ffff, "R7 le32");
    // R3: narrow form with all lanes true gives 0xF only
    drive(1, EQ16, 64'hcafe_cafe_cafe_cafe, 64'hcafe_cafe_cafe_cafe, "R3 eq16 all");
    // R11 gap, then R9 illegal and R11 idle hold
    idle();
    drive(1, 9'h030, 64'h1, 64'h1, "R9 illegal 0x030");
    drive(1, 9'h000, 64'h1, 64'h1, "R9 illegal 0x000");
    idle();
    drive(1, NE16, 64'h0, 64'h0, "R6 ne16 all equal");
    drive(1, GT16, 64'h0001_0001_0001_0001, 64'h0000_0000_0000_0000, "R2 gt16 all");

    // Mixed sweep over every encoding (R1, R2, R8)
    for (int k = 0; k < 64; k++) begin
      logic [8:0] ops[8] = '{LE16, NE16, LE32, NE32, GT16, EQ16, GT32, EQ32};
      logic [63:0] a = {$urandom, $urandom};
      logic [63:0] b = {$urandom, $urandom};
      if (k % 2 == 0) begin b[15:0] = a[15:0]; b[63:32] = a[63:32]; end
      if (k % 7 == 3) idle();
      drive(1, ops[k % 8], a, b, "R8 R1 sweep");
    end
    idle();
    @(posedge clk); #2;

    // R10: reset with a valid legal input in the same cycle
    @(negedge clk);
    rst = 1'b1; inValid = 1'b1; inOpcode = EQ16; inSrcA = '0; inSrcB = '0;
    @(posedge clk); #1 checkZero("R10 reset overrides valid");
    @(negedge clk);
    rst = 1'b0; inValid = 1'b0;
    lastRes = '0;
    idle();
    drive(1, LE16, 64'h0, 64'h0, "R10 after reset");
    idle();
    @(posedge clk); #2;
    finishRun();
  end

endmodule